// File: doc/BRIEF.md
# Limit Counter Timer with Modes

This block is a count-up timer reached through a small word-addressed register port. A prescaler turns the core clock into a tick every 500 ns, which is 25 clocks at the default 50 MHz. A 64-bit counter advances on each tick. The counter is compared against a 32-bit limit register at a resolution of 512, so the number of ticks that counts is the limit shifted right by 9. When the counter reaches that value, a sticky reached flag is set. In the interrupting modes, a level interrupt also rises and the counter starts again from zero, which makes the timer periodic.

There are three modes. The processor and system modes raise the interrupt. The user mode turns the timer into a free-running counter that never interrupts. Software acknowledges an interrupt by reading the limit word. Two write offsets load the limit: one also clears the counter and the other leaves the counter running. Only a timer in processor or user mode may change its mode. A system timer stays in system mode. The 64-bit count is read in two halves. Reading the high half captures the low half, so a later read of the low half matches the same instant.

Top module: `lctimer`

## Requirements
- R1: After reset the interrupt is low and the timer is stopped (run bit 0). The limit, both counter halves and the control word read 0, and the mode word reads the INIT_MODE value (0 processor, 1 user, 2 system).
- R2: While the run bit (bit 0 of the control word at offset 4) is 1, the counter advances once every TICK_DIV clocks. While the run bit is 0, the counter and the prescaler phase hold their values.
- R3: On the tick where counter+1 equals limit>>9 (a non-zero value), the reached flag is set. The reached flag reads as bit 31 of the control word. In modes 0 and 2, the interrupt rises at that same clock edge and the counter restarts from 0, so the next hit follows (limit>>9)*TICK_DIV clocks later.
- R4: A read of offset 0 in modes 0 and 2 lowers the interrupt and clears the reached flag. A read of offset 0 or offset 2 returns the limit with bit 31 forced to 0 in modes 0 and 2, and returns the full limit in user mode. A read of offset 2 has no side effect.
- R5: A write to offset 0 loads the limit, clears the counter and the prescaler phase, and lowers the interrupt.
- R6: A write to offset 2 loads the limit and leaves the counter, the prescaler phase and the interrupt unchanged.
- R7: A write to offset 5 sets the mode to bit 0 of the written value (0 processor, 1 user), but only when the current mode is 0 or 1. A timer in mode 2 ignores the write.
- R8: Entering user mode lowers the interrupt and sets the limit to all ones. The interrupt never rises while the timer is in user mode.
- R9: A read of offset 1 returns counter bits 63:32 and captures counter bits 31:0. A read of offset 3 returns the captured value, not the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one clock after rd_en |
| irq | output | 1 | Level interrupt |

## Verification
A write or a read takes effect at the clock edge where its strobe is sampled. Read data appears after that same edge, and the bench samples it on the following falling edge. The bench counts clock edges from the edge that loads a limit through offset 0 to the falling edge where the interrupt is first seen high, and expects exactly (limit>>9)*TICK_DIV. When one or more register accesses sit between a hit and the next one, it expects that figure minus the number of access edges. Counter snapshots are predicted as floor(edges/TICK_DIV), taken at the edge before the high-half read. These predictions include the prescaler phase that was held across a stop.

// File: rtl/lctimer_pkg.sv
package lctimer_pkg;
  typedef enum logic [1:0] {
    MODE_CPU  = 2'd0,
    MODE_USER = 2'd1,
    MODE_SYS  = 2'd2
  } tmode_e;

  localparam logic [2:0] OFS_LIM_CLR  = 3'd0;
  localparam logic [2:0] OFS_CNT_HI   = 3'd1;
  localparam logic [2:0] OFS_LIM_KEEP = 3'd2;
  localparam logic [2:0] OFS_CNT_LO   = 3'd3;
  localparam logic [2:0] OFS_CTRL     = 3'd4;
  localparam logic [2:0] OFS_MODE     = 3'd5;
endpackage

// File: rtl/lctimer_presc.sv
module lctimer_presc #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q, pre_d;

  assign tick = run && (pre_q == PW'(DIV - 1));

  always_comb begin
    pre_d = pre_q;
    if (restart)  pre_d = '0;
    else if (run) pre_d = tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/lctimer_count.sv
module lctimer_count #(
  parameter int CNT_W = 64,
  parameter int SHIFT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             wrap_en,
  input  logic [31:0]      limit,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_eff;

  assign lim_eff = CNT_W'(limit >> SHIFT);
  assign hit     = tick && !clr && (lim_eff != '0) && (cnt_q + 1'b1 == lim_eff);
  assign cnt     = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = (hit && wrap_en) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q)); // R2
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R5
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wrap_en) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/lctimer_regs.sv
module lctimer_regs
  import lctimer_pkg::*;
#(
  parameter int     CNT_W     = 64,
  parameter tmode_e INIT_MODE = MODE_CPU
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             hit,
  output logic [31:0]      rdata,
  output logic             irq,
  output logic             run,
  output logic [31:0]      limit,
  output logic             ctr_clr,
  output logic             wrap_en
);
  tmode_e      mode_q, mode_d;
  logic [31:0] limit_q, limit_d, lo_q, lo_d, rdata_q, rdata_d;
  logic        run_q, run_d, irq_q, irq_d, reached_q, reached_d;
  logic        user, wr_lim0, wr_lim2, wr_mode, wr_ctrl, ack, enter_user;

  assign user       = (mode_q == MODE_USER);
  assign wr_lim0    = wr_en && (addr == OFS_LIM_CLR);
  assign wr_lim2    = wr_en && (addr == OFS_LIM_KEEP);
  assign wr_mode    = wr_en && (addr == OFS_MODE);
  assign wr_ctrl    = wr_en && (addr == OFS_CTRL);
  assign ack        = rd_en && (addr == OFS_LIM_CLR) && !user;
  assign enter_user = (mode_d == MODE_USER) && !user;

  always_comb begin
    mode_d = mode_q;
    if (wr_mode && (mode_q == MODE_CPU || mode_q == MODE_USER))
      mode_d = wdata[0] ? MODE_USER : MODE_CPU;

    limit_d = limit_q;
    if (wr_lim0 || wr_lim2) limit_d = wdata;
    if (enter_user)         limit_d = '1;

    run_d = wr_ctrl ? wdata[0] : run_q;

    reached_d = reached_q;
    if (ack) reached_d = 1'b0;
    if (hit) reached_d = 1'b1;

    irq_d = irq_q;
    if (ack || wr_lim0)  irq_d = 1'b0;
    if (hit && !user)    irq_d = 1'b1;
    if (enter_user)      irq_d = 1'b0;

    lo_d = lo_q;
    if (rd_en && addr == OFS_CNT_HI) lo_d = cnt[31:0];

    rdata_d = rdata_q;
    if (rd_en) begin
      case (addr)
        OFS_LIM_CLR,
        OFS_LIM_KEEP: rdata_d = user ? limit_q : {1'b0, limit_q[30:0]};
        OFS_CNT_HI:   rdata_d = 32'(cnt >> 32);
        OFS_CNT_LO:   rdata_d = lo_q;
        OFS_CTRL:     rdata_d = {reached_q, 30'd0, run_q};
        OFS_MODE:     rdata_d = {30'd0, mode_q};
        default:      rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= INIT_MODE;
      limit_q   <= '0;
      run_q     <= 1'b0;
      irq_q     <= 1'b0;
      reached_q <= 1'b0;
      lo_q      <= '0;
      rdata_q   <= '0;
    end else begin
      mode_q    <= mode_d;
      limit_q   <= limit_d;
      run_q     <= run_d;
      irq_q     <= irq_d;
      reached_q <= reached_d;
      lo_q      <= lo_d;
      rdata_q   <= rdata_d;
    end
  end

  assign rdata   = rdata_q;
  assign irq     = irq_q;
  assign run     = run_q;
  assign limit   = limit_q;
  assign ctr_clr = wr_lim0;
  assign wrap_en = !user;

  AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_USER) |-> !irq_q); // R8
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_LIM_CLR && mode_q != MODE_USER && !hit) |=> (!irq_q && !reached_q)); // R4
  AST_SYS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SYS) |=> (mode_q == MODE_SYS)); // R7
  AST_HIT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q != MODE_USER && !(wr_en && addr == OFS_MODE)) |=> (irq_q && reached_q)); // R3
  AST_KEEP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_LIM_KEEP && !hit && !rd_en) |=> $stable(irq_q)); // R6
endmodule

// File: rtl/lctimer.sv
module lctimer
  import lctimer_pkg::*;
#(
  parameter int     TICK_DIV  = 25,
  parameter int     CNT_W     = 64,
  parameter int     LIM_SHIFT = 9,
  parameter tmode_e INIT_MODE = MODE_CPU
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  logic             run, tick, ctr_clr, wrap_en, hit;
  logic [31:0]      limit;
  logic [CNT_W-1:0] cnt;

  lctimer_presc #(.DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ctr_clr), .tick(tick)
  );

  lctimer_count #(.CNT_W(CNT_W), .SHIFT(LIM_SHIFT)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(ctr_clr), .wrap_en(wrap_en),
    .limit(limit), .cnt(cnt), .hit(hit)
  );

  lctimer_regs #(.CNT_W(CNT_W), .INIT_MODE(INIT_MODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .hit(hit), .rdata(rdata), .irq(irq),
    .run(run), .limit(limit), .ctr_clr(ctr_clr), .wrap_en(wrap_en)
  );
endmodule

// File: tb/lctimer_tb.sv
module lctimer_tb;
  import lctimer_pkg::*;

  localparam int P = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_sys;
  logic        irq, irq_sys;
  int          tests = 0, fails = 0;
  logic [31:0] q, qs;
  int          n;

  always #10 clk = ~clk;

  lctimer #(.TICK_DIV(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  lctimer #(.TICK_DIV(P), .INIT_MODE(MODE_SYS)) u_dut_sys (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_sys), .irq(irq_sys)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    q = rdata; qs = rdata_sys;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_irq(output int cnt_out);
    cnt_out = 0;
    do begin
      @(posedge clk); @(negedge clk);
      cnt_out++;
    end while (!irq && cnt_out < 2000);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(OFS_LIM_CLR); chk("R1 limit", q, 0);
    rd(OFS_MODE);    chk("R1 mode", q, 0); chk("R1 sys mode", qs, 2);
    rd(OFS_CTRL);    chk("R1 ctrl", q, 0);
    idle(50);
    rd(OFS_CNT_HI);  chk("R1 hi", q, 0);
    rd(OFS_CNT_LO);  chk("R1 stopped lo", q, 0);

    // R9/R2 count and capture; edges counted from the offset-0 write
    wr(OFS_CTRL, 32'd1);
    wr(OFS_LIM_CLR, 32'h7FFF_FE00);          // E0
    idle(130);                                // E1..E130
    rd(OFS_CNT_HI);  chk("R9 hi", q, 0);      // E131 captures floor(130/25)
    rd(OFS_CNT_LO);  chk("R2 R9 lo", q, 5);   // E132
    idle(60);                                 // E133..E192
    rd(OFS_CNT_LO);  chk("R9 lo held", q, 5); // E193
    wr(OFS_CTRL, 32'd0);                      // E194, ticks at E175
    rd(OFS_CNT_HI);                           // E195
    rd(OFS_CNT_LO);  chk("R2 at stop", q, 7);
    idle(100);
    rd(OFS_CNT_HI);
    rd(OFS_CNT_LO);  chk("R2 hold stopped", q, 7);

    // R6 limit load keeps counter and phase (phase 19 held)
    wr(OFS_LIM_KEEP, 32'd9 << 9);
    rd(OFS_CNT_HI);
    rd(OFS_CNT_LO);  chk("R6 counter kept", q, 7);
    wr(OFS_CTRL, 32'd1);
    wait_irq(n);     chk("R6 R3 phase kept", n, 31);
    wr(OFS_LIM_KEEP, 32'd9 << 9);
    chk("R6 irq kept", irq, 1);
    wr(OFS_LIM_CLR, 32'd9 << 9);
    chk("R5 irq low", irq, 0);
    rd(OFS_CNT_HI);
    rd(OFS_CNT_LO);  chk("R5 counter cleared", q, 0);

    // R3/R4 sweep of limits
    for (int l = 1; l <= 6; l++) begin
      wr(OFS_LIM_CLR, 32'(l) << 9);
      wait_irq(n);     chk("R3 first hit", n, l * P);
      rd(OFS_CTRL);    chk("R3 reached", q[31], 1);
      rd(OFS_LIM_CLR); chk("R4 readback", q, 32'(l) << 9);
      chk("R4 irq acked", irq, 0);
      rd(OFS_CTRL);    chk("R4 reached cleared", q[31], 0);
      wait_irq(n);     chk("R3 periodic", n, l * P - 3);
    end

    // R8 user mode
    chk("R8 pre irq", irq, 1);
    wr(OFS_MODE, 32'd1);
    chk("R8 irq low", irq, 0);
    rd(OFS_LIM_KEEP); chk("R8 R4 user limit", q, 32'hFFFF_FFFF);
    chk("R7 sys limit kept", qs, 32'd6 << 9);
    rd(OFS_MODE);    chk("R7 user mode", q, 1); chk("R7 sys ignores", qs, 2);
    idle(300);
    chk("R8 no irq in user", irq, 0);
    wr(OFS_MODE, 32'd0);
    rd(OFS_MODE);    chk("R7 back to cpu", q, 0);
    rd(OFS_LIM_KEEP); chk("R4 masked bit31", q, 32'h7FFF_FFFF);
    chk("R4 offset2 no ack", irq, 0);

    summary();
    $finish;
  end
endmodule